// File: doc/BRIEF.md
# Phase Error Statistics Collector

This block sits beside a line-locked clock loop. Once per video line it takes one signed phase-error sample, and it gathers statistics over a window whose length in lines is a power of two set by software. When the last line of a window arrives, the block publishes three results at the same time: the average error, the spread between the largest and smallest error, and the total of the error magnitudes. One count of each result stands for roughly 200 ps of phase.

Software reaches the block through a small byte-wide register port. Writes are strobed and reads are combinational. A control byte turns collection on or off and chooses between two ways of publishing. In continuous publishing, windows follow one another without a gap and a status bit inverts at every publish. In single-capture publishing, one window is measured, a ready bit goes high and stays high, and collection stops until software re-arms the block.

Top module: `pes_collector`

## Requirements
- R1: While reset is held, and after it, the control byte (address 0) reads 0x00 and the window byte (address 1) reads 0x04. Addresses 2 to 6 read 0x00.
- R2: Control byte at address 0: bit 0 is enable, bit 1 is mode (0 continuous, 1 single-capture), bit 7 is the update flag, and bits 6 to 2 read 0. A write to bit 7 has no effect. While enable is 0, line strobes change no result and do not change the flag.
- R3: Window byte at address 1 holds k, and a window is 2^k lines. A written value above 8 is stored as 8. Bits 7 to 4 read 0. Any write to address 0 or address 1 restarts the current window from its first line.
- R4: In continuous mode the flag inverts at each publish, and the next window starts on the next accepted strobe.
- R5: In single-capture mode the flag is set at the publish, and strobes are ignored while it stays set. Writing the control byte with bits 1 and 0 both 1 clears the flag and starts a fresh window.
- R6: Address 2 holds the mean: the signed sum of the window shifted right by k with the sign kept (rounding toward minus infinity), then clamped to the 8-bit two's-complement range -128 to 127.
- R7: Addresses 3 (low byte) and 4 (high byte) hold the maximum minus the minimum sample of the window, clamped to 65535.
- R8: Addresses 5 (low byte) and 6 (high byte) hold the sum of the magnitudes of the window's samples. The sum saturates at 65535 and does not wrap.
- R9: All results change only in the cycle after the strobe that completes a window. They hold their value until the next publish.
- R10: A line strobe in the same cycle as a write to address 0 or 1 is discarded. The window restarts without that sample.
- R11: Address 7 reads 0x00. Writes to addresses 2 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_stb | input | 1 | One-cycle pulse, one per line, that qualifies phase_err |
| phase_err | input | 12 | Signed phase-error sample (two's complement) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |

## Verification
Two functions can land in the same cycle: a software write that restarts the window, and the line strobe that would close that window. The bench forces this case by issuing a write to the control byte in the exact cycle of the final strobe of a window. The reference model then requires that no publish happens, that the flag keeps its value, and that the next full window is counted from scratch. Random runs also mix control and window writes with random strobes, so the same collision occurs on windows of several lengths and in both modes.

// File: rtl/pes_pkg.sv
package pes_pkg;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_WIN   = 3'd1;
  localparam logic [2:0] ADR_MEAN  = 3'd2;
  localparam logic [2:0] ADR_PP_LO = 3'd3;
  localparam logic [2:0] ADR_PP_HI = 3'd4;
  localparam logic [2:0] ADR_AB_LO = 3'd5;
  localparam logic [2:0] ADR_AB_HI = 3'd6;

  typedef enum logic {
    MODE_FREE = 1'b0,
    MODE_ONCE = 1'b1
  } upd_mode_e;

endpackage

// File: rtl/pes_rst_sync.sv
module pes_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pes_regs.sv
module pes_regs
  import pes_pkg::*;
#(
  parameter int LOG_MAX   = 8,
  parameter int LOG_RESET = 4,
  localparam int LOG_W    = $clog2(LOG_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             line_stb_i,
  input  logic             publish_i,
  output upd_mode_e        mode_o,
  output logic             en_o,
  output logic [LOG_W-1:0] winlog_o,
  output logic             flag_o,
  output logic             accept_o,
  output logic             restart_o
);

  upd_mode_e        mode_q, mode_d;
  logic             en_q, en_d;
  logic [LOG_W-1:0] win_q, win_d;
  logic             flag_q, flag_d;
  logic             ctrl_wr, win_wr, halted, reg_ce;

  always_comb begin
    ctrl_wr   = we_i && (addr_i == ADR_CTRL);
    win_wr    = we_i && (addr_i == ADR_WIN);
    restart_o = ctrl_wr || win_wr;
    halted    = (mode_q == MODE_ONCE) && flag_q;
    accept_o  = line_stb_i && en_q && !halted && !restart_o;
    reg_ce    = restart_o || publish_i;
  end

  always_comb begin
    mode_d = mode_q;
    en_d   = en_q;
    win_d  = win_q;
    flag_d = flag_q;
    if (ctrl_wr) begin
      mode_d = upd_mode_e'(wdata_i[1]);
      en_d   = wdata_i[0];
      if (wdata_i[1] && wdata_i[0]) begin
        flag_d = 1'b0;
      end
    end
    if (win_wr) begin
      if (wdata_i > 8'(LOG_MAX)) begin
        win_d = LOG_W'(LOG_MAX);
      end else begin
        win_d = wdata_i[LOG_W-1:0];
      end
    end
    if (publish_i) begin
      flag_d = (mode_q == MODE_ONCE) ? 1'b1 : ~flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FREE;
      en_q   <= 1'b0;
      win_q  <= LOG_W'(LOG_RESET);
      flag_q <= 1'b0;
    end else if (reg_ce) begin
      mode_q <= mode_d;
      en_q   <= en_d;
      win_q  <= win_d;
      flag_q <= flag_d;
    end
  end

  assign mode_o   = mode_q;
  assign en_o     = en_q;
  assign winlog_o = win_q;
  assign flag_o   = flag_q;

  // R5
  once_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_ONCE) && flag_q && !ctrl_wr) |=> flag_q);

  // R4
  free_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (publish_i && (mode_q == MODE_FREE)) |=> (flag_q != $past(flag_q)));

  // R2
  idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctrl_wr) |=> $stable(flag_q));

endmodule

// File: rtl/pes_accum.sv
module pes_accum #(
  parameter int ERR_W   = 12,
  parameter int LOG_MAX = 8,
  parameter int ABS_W   = 16,
  localparam int LOG_W  = $clog2(LOG_MAX + 1),
  localparam int SUM_W  = ERR_W + LOG_MAX,
  localparam int CNT_W  = LOG_MAX
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept_i,
  input  logic                    restart_i,
  input  logic [LOG_W-1:0]        winlog_i,
  input  logic signed [ERR_W-1:0] sample_i,
  output logic                    publish_o,
  output logic signed [SUM_W-1:0] sum_nx_o,
  output logic signed [ERR_W-1:0] max_nx_o,
  output logic signed [ERR_W-1:0] min_nx_o,
  output logic [ABS_W-1:0]        abs_nx_o
);

  logic [CNT_W-1:0]        cnt_q, cnt_d, last_cnt;
  logic [CNT_W:0]          span;
  logic signed [SUM_W-1:0] sum_q;
  logic signed [ERR_W-1:0] max_q, min_q;
  logic [ABS_W-1:0]        abs_q;
  logic                    first;
  logic signed [SUM_W-1:0] samp_ext;
  logic signed [ERR_W:0]   samp_w;
  logic [ERR_W:0]          mag;
  logic [ABS_W:0]          abs_wide;
  logic                    cnt_ce;

  always_comb begin
    span     = {{CNT_W{1'b0}}, 1'b1} << winlog_i;
    last_cnt = CNT_W'(span - 1'b1);
    first    = (cnt_q == '0);
    samp_ext = {{LOG_MAX{sample_i[ERR_W-1]}}, sample_i};
    samp_w   = {sample_i[ERR_W-1], sample_i};
    mag      = samp_w[ERR_W] ? (~samp_w + 1'b1) : samp_w;
  end

  always_comb begin
    sum_nx_o = first ? samp_ext : (sum_q + samp_ext);
    max_nx_o = (first || (sample_i > max_q)) ? sample_i : max_q;
    min_nx_o = (first || (sample_i < min_q)) ? sample_i : min_q;
    abs_wide = (first ? {(ABS_W+1){1'b0}} : {1'b0, abs_q})
             + {{(ABS_W-ERR_W){1'b0}}, mag};
    abs_nx_o = abs_wide[ABS_W] ? {ABS_W{1'b1}} : abs_wide[ABS_W-1:0];
    publish_o = accept_i && (cnt_q == last_cnt);
  end

  always_comb begin
    cnt_ce = accept_i || restart_i;
    cnt_d  = cnt_q;
    if (restart_i) begin
      cnt_d = '0;
    end else if (accept_i) begin
      cnt_d = publish_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      max_q <= '0;
      min_q <= '0;
      abs_q <= '0;
    end else if (accept_i) begin
      sum_q <= sum_nx_o;
      max_q <= max_nx_o;
      min_q <= min_nx_o;
      abs_q <= abs_nx_o;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt);

  // R10
  collide_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |-> !publish_o);

  // R8
  abs_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && (cnt_q != '0)) |=> (abs_q >= $past(abs_q)));

endmodule

// File: rtl/pes_result.sv
module pes_result #(
  parameter int ERR_W   = 12,
  parameter int LOG_MAX = 8,
  parameter int ABS_W   = 16,
  parameter int PP_W    = 16,
  parameter int MEAN_W  = 8,
  localparam int LOG_W  = $clog2(LOG_MAX + 1),
  localparam int SUM_W  = ERR_W + LOG_MAX
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    publish_i,
  input  logic [LOG_W-1:0]        winlog_i,
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic signed [ERR_W-1:0] max_i,
  input  logic signed [ERR_W-1:0] min_i,
  input  logic [ABS_W-1:0]        abs_i,
  output logic [MEAN_W-1:0]       mean_o,
  output logic [PP_W-1:0]         pp_o,
  output logic [ABS_W-1:0]        abs_o
);

  logic signed [SUM_W-1:0]  shifted;
  logic [SUM_W-MEAN_W:0]    top_bits;
  logic                     fits;
  logic [MEAN_W-1:0]        mean_nx;
  logic [ERR_W:0]           diff;
  logic [PP_W-1:0]          pp_nx;
  logic [MEAN_W-1:0]        mean_q;
  logic [PP_W-1:0]          pp_q;
  logic [ABS_W-1:0]         abs_q;

  always_comb begin
    shifted  = sum_i >>> winlog_i;
    top_bits = shifted[SUM_W-1:MEAN_W-1];
    fits     = (top_bits == '0) || (top_bits == '1);
    if (fits) begin
      mean_nx = shifted[MEAN_W-1:0];
    end else if (shifted[SUM_W-1]) begin
      mean_nx = {1'b1, {(MEAN_W-1){1'b0}}};
    end else begin
      mean_nx = {1'b0, {(MEAN_W-1){1'b1}}};
    end
    diff = {max_i[ERR_W-1], max_i} - {min_i[ERR_W-1], min_i};
  end

  generate
    if (ERR_W + 1 <= PP_W) begin : g_pp_fit
      assign pp_nx = PP_W'(diff);
    end else begin : g_pp_sat
      assign pp_nx = (|diff[ERR_W:PP_W]) ? {PP_W{1'b1}} : diff[PP_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mean_q <= '0;
      pp_q   <= '0;
      abs_q  <= '0;
    end else if (publish_i) begin
      mean_q <= mean_nx;
      pp_q   <= pp_nx;
      abs_q  <= abs_i;
    end
  end

  assign mean_o = mean_q;
  assign pp_o   = pp_q;
  assign abs_o  = abs_q;

  // R7
  pp_le_abs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    publish_i |=> (32'(abs_q) >= 32'(pp_q)));

endmodule

// File: rtl/pes_collector.sv
module pes_collector
  import pes_pkg::*;
#(
  parameter int ERR_W     = 12,
  parameter int LOG_MAX   = 8,
  parameter int LOG_RESET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_stb,
  input  logic [ERR_W-1:0] phase_err,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata
);

  localparam int LOG_W  = $clog2(LOG_MAX + 1);
  localparam int SUM_W  = ERR_W + LOG_MAX;
  localparam int RES_W  = 16;
  localparam int MEAN_W = 8;

  logic                    rst_i_n;
  upd_mode_e               mode;
  logic                    en, flag, accept, restart, publish;
  logic [LOG_W-1:0]        winlog;
  logic signed [SUM_W-1:0] sum_nx;
  logic signed [ERR_W-1:0] max_nx, min_nx;
  logic [RES_W-1:0]        abs_nx;
  logic [MEAN_W-1:0]       mean_r;
  logic [RES_W-1:0]        pp_r, abs_r;

  pes_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pes_regs #(.LOG_MAX(LOG_MAX), .LOG_RESET(LOG_RESET)) u_regs (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .we_i       (reg_we),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .line_stb_i (line_stb),
    .publish_i  (publish),
    .mode_o     (mode),
    .en_o       (en),
    .winlog_o   (winlog),
    .flag_o     (flag),
    .accept_o   (accept),
    .restart_o  (restart)
  );

  pes_accum #(.ERR_W(ERR_W), .LOG_MAX(LOG_MAX), .ABS_W(RES_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .accept_i  (accept),
    .restart_i (restart),
    .winlog_i  (winlog),
    .sample_i  (phase_err),
    .publish_o (publish),
    .sum_nx_o  (sum_nx),
    .max_nx_o  (max_nx),
    .min_nx_o  (min_nx),
    .abs_nx_o  (abs_nx)
  );

  pes_result #(.ERR_W(ERR_W), .LOG_MAX(LOG_MAX), .ABS_W(RES_W),
               .PP_W(RES_W), .MEAN_W(MEAN_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .publish_i (publish),
    .winlog_i  (winlog),
    .sum_i     (sum_nx),
    .max_i     (max_nx),
    .min_i     (min_nx),
    .abs_i     (abs_nx),
    .mean_o    (mean_r),
    .pp_o      (pp_r),
    .abs_o     (abs_r)
  );

  always_comb begin
    case (reg_addr)
      ADR_CTRL:  reg_rdata = {flag, 5'b0, (mode == MODE_ONCE), en};
      ADR_WIN:   reg_rdata = 8'(winlog);
      ADR_MEAN:  reg_rdata = mean_r;
      ADR_PP_LO: reg_rdata = pp_r[7:0];
      ADR_PP_HI: reg_rdata = pp_r[15:8];
      ADR_AB_LO: reg_rdata = abs_r[7:0];
      ADR_AB_HI: reg_rdata = abs_r[15:8];
      default:   reg_rdata = 8'h00;
    endcase
  end

endmodule

// File: tb/tb_pes_collector.sv
`timescale 1ns/1ps
module tb_pes_collector;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_stb;
  logic [11:0] phase_err;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;

  int checks = 0;
  int errors = 0;
  string ph = "R1";

  // behavioural model state
  int m_mode, m_en, m_win, m_flag, m_cnt;
  int m_sum, m_max, m_min, m_abs;
  int r_mean, r_pp, r_abs;
  int rd_ptr = 0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  pes_collector dut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .phase_err(phase_err),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic string tagof(input int a);
    case (a)
      0: return "R2 R4 R5";
      1: return "R3";
      2: return "R6 R9";
      3, 4: return "R7 R9";
      5, 6: return "R8 R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    case (a)
      0: return {m_flag[0], 5'b0, m_mode[0], m_en[0]};
      1: return 8'(m_win);
      2: return r_mean[7:0];
      3: return 8'(r_pp & 255);
      4: return 8'(r_pp >> 8);
      5: return 8'(r_abs & 255);
      6: return 8'(r_abs >> 8);
      default: return 8'h00;
    endcase
  endfunction

  function automatic int unsigned nextrand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic model_reset();
    m_mode = 0; m_en = 0; m_win = 4; m_flag = 0; m_cnt = 0;
    m_sum = 0; m_max = 0; m_min = 0; m_abs = 0;
    r_mean = 0; r_pp = 0; r_abs = 0;
  endtask

  task automatic compare(input int a);
    logic [7:0] e;
    e = exp_read(a);
    checks++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s %s addr=%0d got=%h exp=%h", ph, tagof(a), a, reg_rdata, e);
    end
  endtask

  task automatic model_next(input bit s, input int e, input bit w,
                            input int a, input int d);
    int mg, mv;
    bit rst_wr;
    rst_wr = w && (a == 0 || a == 1);
    if (rst_wr) begin
      m_cnt = 0;
      if (a == 0) begin
        m_mode = (d >> 1) & 1;
        m_en   = d & 1;
        if (m_mode == 1 && m_en == 1) m_flag = 0;
      end else begin
        m_win = (d > 8) ? 8 : d;
      end
    end else if (s && m_en == 1 && !(m_mode == 1 && m_flag == 1)) begin
      mg = (e < 0) ? -e : e;
      if (m_cnt == 0) begin
        m_sum = e; m_max = e; m_min = e; m_abs = mg;
      end else begin
        m_sum += e;
        if (e > m_max) m_max = e;
        if (e < m_min) m_min = e;
        m_abs = (m_abs + mg > 65535) ? 65535 : m_abs + mg;
      end
      if (m_cnt == (1 << m_win) - 1) begin
        mv = m_sum >>> m_win;
        if (mv > 127) mv = 127;
        if (mv < -128) mv = -128;
        r_mean = mv;
        r_pp   = (m_max - m_min > 65535) ? 65535 : m_max - m_min;
        r_abs  = m_abs;
        m_flag = (m_mode == 1) ? 1 : (m_flag ^ 1);
        m_cnt  = 0;
      end else begin
        m_cnt++;
      end
    end
  endtask

  // one clock: drive at negedge, check, advance model, wait next negedge
  task automatic step(input bit s, input int e, input bit w,
                      input int a, input int d);
    line_stb  = s;
    phase_err = 12'(e);
    reg_we    = w;
    reg_addr  = 3'(a);
    reg_wdata = 8'(d);
    #1;
    compare(a);
    model_next(s, e, w, a, d);
    @(negedge clk);
  endtask

  task automatic strobe(input int e);
    step(1'b1, e, 1'b0, rd_ptr, 0);
    rd_ptr = (rd_ptr + 1) % 8;
  endtask

  task automatic idle();
    step(1'b0, 0, 1'b0, rd_ptr, 0);
    rd_ptr = (rd_ptr + 1) % 8;
  endtask

  task automatic wr(input int a, input int d);
    step(1'b0, 0, 1'b1, a, d);
  endtask

  task automatic sweep();
    for (int a = 0; a < 8; a++) step(1'b0, 0, 1'b0, a, 0);
  endtask

  function automatic int rnd_err();
    return int'(nextrand() % 4096) - 2048;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    rst_n = 1'b0; line_stb = 1'b0; phase_err = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    @(negedge clk);
    // R1: reset values seen while reset is held
    ph = "R1";
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a);
      #1;
      compare(a);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();
    sweep();

    // R2: disabled, strobes have no effect
    ph = "R2";
    for (int i = 0; i < 24; i++) strobe(rnd_err());
    sweep();

    // R4: single-line window, continuous mode
    ph = "R4";
    wr(1, 0);
    wr(0, 1);
    for (int i = 0; i < 10; i++) begin strobe(rnd_err()); step(1'b0, 0, 1'b0, 0, 0); end
    sweep();

    // R9: four-line windows with gaps between strobes
    ph = "R9";
    wr(1, 2);
    for (int i = 0; i < 80; i++) begin
      if (nextrand() % 2 == 0) strobe(rnd_err()); else idle();
    end
    sweep();

    // R6 R7: extremes over 8 lines
    ph = "R6";
    wr(1, 3);
    for (int i = 0; i < 8; i++) strobe(2047);
    sweep();
    for (int i = 0; i < 8; i++) strobe(-2048);
    sweep();
    ph = "R7";
    for (int i = 0; i < 8; i++) strobe((i % 2 == 0) ? 2047 : -2048);
    sweep();

    // R3: clamp of window value, then R8 saturation over 256 lines
    ph = "R3";
    wr(1, 15);
    step(1'b0, 0, 1'b0, 1, 0);
    wr(1, 8'h93);
    step(1'b0, 0, 1'b0, 1, 0);
    ph = "R8";
    for (int i = 0; i < 256; i++) strobe(-2048);
    sweep();

    // R5: single-capture mode
    ph = "R5";
    wr(1, 2);
    wr(0, 3);
    for (int i = 0; i < 12; i++) strobe(rnd_err());
    sweep();
    wr(0, 3);
    for (int i = 0; i < 6; i++) strobe(rnd_err());
    sweep();

    // R10: control write collides with the closing strobe
    ph = "R10";
    wr(1, 1);
    wr(0, 1);
    strobe(300);
    step(1'b1, -700, 1'b1, 0, 1);
    sweep();
    strobe(5);
    strobe(-9);
    sweep();
    step(1'b1, 100, 1'b1, 1, 1);
    strobe(40);
    strobe(41);
    sweep();

    // R11: writes to result addresses ignored
    ph = "R11";
    for (int a = 2; a < 8; a++) wr(a, 8'hA5);
    sweep();

    // R2: disable in mid window, then re-enable
    ph = "R2";
    wr(1, 2);
    strobe(11);
    wr(0, 0);
    for (int i = 0; i < 6; i++) strobe(rnd_err());
    sweep();
    wr(0, 1);
    for (int i = 0; i < 8; i++) strobe(rnd_err());
    sweep();

    // random mix over both modes and all window lengths
    ph = "R4 R5 R10";
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = nextrand() % 100;
      if (r < 2)      step(nextrand() % 2 == 0, rnd_err(), 1'b1, 0, int'(nextrand() % 4));
      else if (r < 3) step(nextrand() % 2 == 0, rnd_err(), 1'b1, 1, int'(nextrand() % 5));
      else if (r < 60) strobe(rnd_err());
      else idle();
    end
    sweep();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule